// File: doc/BRIEF.md
# Dual-Mode Clocked FIFO with Status Flags

This block is a first-in first-out buffer for 18-bit words. Its write and read ports each run on their own free-running clock. The two clocks may be unrelated or may be the same net. Both pointers cross between the clock domains as Gray codes through two-flop synchronizers. Empty is decided on the read side and full on the write side.

A mode pin is captured while reset is held low and selects the read timing:

- **Standard timing**: a word moves to the output register only when a read is requested.
- **Fall-through timing**: the oldest word is pushed to the output register without any request, and a read request consumes it.

The block has five status outputs:

- A read-side flag that means "nothing to read".
- A write-side flag that means "cannot accept".
- Programmable almost-empty and almost-full flags.
- A half-full flag.

The two thresholds default to 7 after reset. A short load sequence, driven through the write port, can replace them. Output enable floats the read data bus when it is low. A build parameter puts either one or two register stages on the empty and full flags.

Top module: `dual_mode_fifo`

## Requirements
- R1: After reset, ef_or=1, ff_ir=0, pae=1, paf=0, hf=0, and rdata=0 with oe=1.
- R2: In standard mode, a rising rclk with ren=1 and a non-empty buffer presents the oldest unread word on rdata after that edge. Words leave in the order they were written.
- R3: In standard mode (FLAG_REGS=1), rdata does not change without a read. The ef_or output is 1 when the buffer is empty. It falls after the second rclk edge that follows the wclk edge that wrote into an empty buffer. It rises after the edge that reads the last word.
- R4: In fall-through mode, the first word written into an empty buffer appears on rdata after the third rclk edge following the write, with ren=0. ef_or (here 1 = no valid word on rdata) falls after that same edge. The word is held until ren=1 on an rclk edge, which replaces it with the next word or raises ef_or.
- R5: ff_ir rises after the wclk edge that stores the DEPTH-th unread word. A write while full is dropped.
- R6: A read while empty is dropped. rdata holds and later traffic is unaffected.
- R7: hf=1 exactly when the write-side occupancy exceeds DEPTH/2.
- R8: pae=1 exactly when the read-side occupancy is at or below the almost-empty offset. The offset defaults to 7.
- R9: paf=1 exactly when the write-side occupancy is at or above DEPTH minus the almost-full offset. The offset defaults to 7.
- R10: A wclk edge with ld=1 and wen=1 stores wdata[AW-1:0] as a threshold rather than as data. The first such edge sets the almost-empty offset and the second sets the almost-full offset. Dropping ld returns the sequence to the first step.
- R11: With oe=0, rdata is all Z. With oe=1, it shows the output register.
- R12: The mode pin (1 = fall-through) is captured only while rst_n is low. Changing it later has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fwft_sel | input | 1 | Read timing select, captured during reset (1 = fall-through) |
| wclk | input | 1 | Write clock |
| wen | input | 1 | Write enable |
| ld | input | 1 | Threshold load select |
| wdata | input | 18 | Write data or threshold value |
| rclk | input | 1 | Read clock |
| ren | input | 1 | Read enable |
| oe | input | 1 | Output enable for rdata |
| rdata | output | 18 | Read data, high impedance when oe=0 |
| ef_or | output | 1 | 1 = nothing to read (empty / output not ready) |
| ff_ir | output | 1 | 1 = full, write not accepted |
| pae | output | 1 | Almost-empty flag |
| paf | output | 1 | Almost-full flag |
| hf | output | 1 | Half-full flag |

## Verification
Each kind of internal fault shows up at the ports in its own way:

- **A read pointer that slips or advances when it should not**: the next read returns a word out of sequence at once, or ef_or rises one read too early or too late. Draining a full buffer word by word catches this on the first wrong word.
- **A synchronizer with one stage too few or too many**: ef_or falls a cycle early or late, and the fall-through first word arrives off its three-edge slot.
- **A wrong threshold register or compare**: pae, paf or hf switches one word away from its boundary, which the bench probes on both sides.
- **A dropped-write fault that still moves the write pointer**: the data read back after a full drain is wrong.

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int DW         = 18,
  parameter int DEPTH      = 512,
  parameter int FLAG_REGS  = 1,
  parameter int AE_DEFAULT = 7,
  parameter int AF_DEFAULT = 7
) (
  input  logic          rst_n,
  input  logic          fwft_sel,
  input  logic          wclk,
  input  logic          wen,
  input  logic          ld,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          ren,
  input  logic          oe,
  output logic [DW-1:0] rdata,
  output logic          ef_or,
  output logic          ff_ir,
  output logic          pae,
  output logic          paf,
  output logic          hf
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wbin, wgray, rsync1, rsync2;
  logic [AW-1:0] ae_off, af_off;
  logic          ld_st, ff_s1;

  logic [PW-1:0] rgray;

  wire           full_now  = (wgray == {~rsync2[PW-1:PW-2], rsync2[PW-3:0]});
  wire           wr_go     = wen & ~ld & ~full_now;
  wire [PW-1:0]  wbin_nxt  = wbin + PW'(wr_go);
  wire [PW-1:0]  wgray_nxt = b2g(wbin_nxt);
  wire           full_d    = (wgray_nxt == {~rsync1[PW-1:PW-2], rsync1[PW-3:0]});
  wire [PW-1:0]  occ_w     = wbin - g2b(rsync2);

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      rsync1 <= '0;
      rsync2 <= '0;
      ae_off <= AW'(AE_DEFAULT);
      af_off <= AW'(AF_DEFAULT);
      ld_st  <= 1'b0;
      ff_s1  <= 1'b0;
    end else begin
      rsync1 <= rgray;
      rsync2 <= rsync1;
      wbin   <= wbin_nxt;
      wgray  <= wgray_nxt;
      ff_s1  <= full_d;
      if (ld && wen) begin
        if (!ld_st) ae_off <= wdata[AW-1:0];
        else        af_off <= wdata[AW-1:0];
        ld_st <= ~ld_st;
      end else if (!ld) begin
        ld_st <= 1'b0;
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_go) mem[wbin[AW-1:0]] <= wdata;
  end

  assign hf  = occ_w > PW'(DEPTH / 2);
  assign paf = occ_w >= (PW'(DEPTH) - PW'(af_off));

  // read domain
  logic          fwft, ov, ef_s1;
  logic [PW-1:0] rbin, wsync1, wsync2;
  logic [DW-1:0] dout;

  always_ff @(posedge rclk) begin
    if (!rst_n) fwft <= fwft_sel;
  end

  wire           empty_now = (rgray == wsync2);
  wire           pull      = fwft ? (~empty_now & (~ov | ren)) : (ren & ~empty_now);
  wire [PW-1:0]  rbin_nxt  = rbin + PW'(pull);
  wire [PW-1:0]  rgray_nxt = b2g(rbin_nxt);
  wire           ov_nxt    = fwft & (pull | (ov & ~ren));
  wire           ef_d      = fwft ? ~ov_nxt : (rgray_nxt == wsync1);
  wire [PW-1:0]  occ_r     = g2b(wsync2) - rbin;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      wsync1 <= '0;
      wsync2 <= '0;
      ov     <= 1'b0;
      ef_s1  <= 1'b1;
      dout   <= '0;
    end else begin
      wsync1 <= wgray;
      wsync2 <= wsync1;
      rbin   <= rbin_nxt;
      rgray  <= rgray_nxt;
      ov     <= ov_nxt;
      ef_s1  <= ef_d;
      if (pull) dout <= mem[rbin[AW-1:0]];
    end
  end

  assign pae   = occ_r <= PW'(ae_off);
  assign rdata = oe ? dout : {DW{1'bz}};

  generate
    if (FLAG_REGS > 1) begin : g_dbl
      logic ef_s2, ff_s2;
      always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) ef_s2 <= 1'b1;
        else        ef_s2 <= ef_s1;
      end
      always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) ff_s2 <= 1'b0;
        else        ff_s2 <= ff_s1;
      end
      assign ef_or = ef_s2;
      assign ff_ir = ff_s2;
    end else begin : g_sgl
      assign ef_or = ef_s1;
      assign ff_ir = ff_s1;
    end
  endgenerate

  assert_no_overflow_R5: assert property (@(posedge wclk) disable iff (!rst_n)
    (full_now && wen) |=> $stable(wbin));
  assert_paf_at_full_R9: assert property (@(posedge wclk) disable iff (!rst_n)
    full_now |-> paf);
  assert_load_not_stored_R10: assert property (@(posedge wclk) disable iff (!rst_n)
    (ld && wen) |=> $stable(wbin));
  assert_no_underflow_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    empty_now |=> $stable(rbin));
  assert_fwft_hold_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft && ov && !ren) |=> (ov && $stable(dout)));
  assert_std_no_spontaneous_R3: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft && !ren) |=> $stable(dout));
endmodule

// File: tb/tb_dual_mode_fifo.sv
module tb_dual_mode_fifo;
  localparam int DW = 18;
  localparam int DEPTH = 512;
  localparam logic [17:0] A1 = 18'h15A5A, A2 = 18'h2A5A5, A3 = 18'h3FFFF,
                          A4 = 18'h00001, A5 = 18'h20000;
  // {wen, ren, wdata, expected rdata, expected ef_or}
  localparam logic [38:0] VEC [16] = '{
    {1'b1, 1'b0, A1, 18'h0, 1'b1},
    {1'b1, 1'b0, A2, 18'h0, 1'b1},
    {1'b0, 1'b0, 18'h0, 18'h0, 1'b0},
    {1'b0, 1'b1, 18'h0, A1, 1'b0},
    {1'b0, 1'b1, 18'h0, A2, 1'b1},
    {1'b0, 1'b1, 18'h0, A2, 1'b1},
    {1'b1, 1'b0, A3, A2, 1'b1},
    {1'b0, 1'b0, 18'h0, A2, 1'b1},
    {1'b0, 1'b0, 18'h0, A2, 1'b0},
    {1'b1, 1'b1, A4, A3, 1'b1},
    {1'b0, 1'b0, 18'h0, A3, 1'b1},
    {1'b0, 1'b0, 18'h0, A3, 1'b0},
    {1'b1, 1'b1, A5, A4, 1'b1},
    {1'b0, 1'b0, 18'h0, A4, 1'b1},
    {1'b0, 1'b0, 18'h0, A4, 1'b0},
    {1'b0, 1'b1, 18'h0, A5, 1'b1}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, fwft_sel = 1'b0, wen = 1'b0, ld = 1'b0, ren = 1'b0, oe = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic ef_or, ff_ir, pae, paf, hf;
  int n_chk = 0, n_fail = 0;

  dual_mode_fifo #(.DW(DW), .DEPTH(DEPTH)) dut (
    .rst_n(rst_n), .fwft_sel(fwft_sel), .wclk(clk), .wen(wen), .ld(ld), .wdata(wdata),
    .rclk(clk), .ren(ren), .oe(oe), .rdata(rdata), .ef_or(ef_or), .ff_ir(ff_ir),
    .pae(pae), .paf(paf), .hf(hf));

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i) ^ 18'h15555;
  endfunction

  task automatic chk(input string req, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; fwft_sel = mode; wen = 0; ren = 0; ld = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic wr(input logic [DW-1:0] d);
    wen = 1'b1; wdata = d;
    step();
    wen = 1'b0;
  endtask

  task automatic rd();
    ren = 1'b1;
    step();
    ren = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    do_reset(1'b0);
    chk("R1", "ef_or", ef_or, 1);
    chk("R1", "ff_ir", ff_ir, 0);
    chk("R1", "pae", pae, 1);
    chk("R1", "paf", paf, 0);
    chk("R1", "hf", hf, 0);
    chk("R1", "rdata", rdata, 0);
    oe = 1'b0; #1;
    chk("R11", "rdata float", (rdata === {DW{1'bz}}), 1);
    oe = 1'b1; #1;
    chk("R11", "rdata driven", rdata, 0);

    for (int i = 0; i < 16; i++) begin
      logic [38:0] v;
      v = VEC[i];
      wen = v[38]; ren = v[37]; wdata = v[36:19];
      step();
      wen = 1'b0; ren = 1'b0;
      chk("R2", $sformatf("row %0d rdata", i), rdata, v[18:1]);
      chk("R3", $sformatf("row %0d ef_or", i), ef_or, v[0]);
      chk("R8", $sformatf("row %0d pae", i), pae, 1);
    end

    // default thresholds, half-full, full, overflow, drain, underflow
    do_reset(1'b0);
    for (int i = 0; i < 7; i++) wr(pat(i));
    step(); step(); step();
    chk("R8", "pae at 7 words", pae, 1);
    wr(pat(7));
    step(); step(); step();
    chk("R8", "pae at 8 words", pae, 0);
    for (int i = 8; i < 256; i++) wr(pat(i));
    chk("R7", "hf at 256", hf, 0);
    wr(pat(256));
    chk("R7", "hf at 257", hf, 1);
    for (int i = 257; i < 504; i++) wr(pat(i));
    chk("R9", "paf at 504", paf, 0);
    wr(pat(504));
    chk("R9", "paf at 505", paf, 1);
    for (int i = 505; i < 511; i++) wr(pat(i));
    chk("R5", "ff_ir at 511", ff_ir, 0);
    wr(pat(511));
    chk("R5", "ff_ir at 512", ff_ir, 1);
    wr(18'h3FFFF);
    chk("R5", "ff_ir after overflow", ff_ir, 1);
    step(); step(); step();
    for (int i = 0; i < DEPTH; i++) begin
      rd();
      chk("R5", $sformatf("drain word %0d", i), rdata, pat(i));
      chk("R3", $sformatf("drain ef %0d", i), ef_or, (i == DEPTH - 1));
    end
    rd();
    chk("R6", "rdata after empty read", rdata, pat(DEPTH - 1));
    chk("R6", "ef_or after empty read", ef_or, 1);
    wr(18'h0ABCD);
    step(); step();
    chk("R6", "ef_or after refill", ef_or, 0);
    rd();
    chk("R6", "word after underflow", rdata, 18'h0ABCD);

    // programmed thresholds
    do_reset(1'b0);
    ld = 1'b1; wen = 1'b1; wdata = 18'd20;
    step();
    wdata = 18'd30;
    step();
    ld = 1'b0; wen = 1'b0;
    step(); step(); step();
    chk("R10", "load not stored ef_or", ef_or, 1);
    for (int i = 0; i < 20; i++) wr(pat(i));
    step(); step(); step();
    chk("R10", "pae at 20 with offset 20", pae, 1);
    wr(pat(20));
    step(); step(); step();
    chk("R10", "pae at 21 with offset 20", pae, 0);
    for (int i = 21; i < 481; i++) wr(pat(i));
    chk("R10", "paf at 481 with offset 30", paf, 0);
    wr(pat(481));
    chk("R10", "paf at 482 with offset 30", paf, 1);

    // fall-through mode
    do_reset(1'b1);
    fwft_sel = 1'b0;
    wr(18'h11111);
    step();
    chk("R4", "edge1 ef_or", ef_or, 1);
    step();
    chk("R4", "edge2 rdata", rdata, 0);
    chk("R4", "edge2 ef_or", ef_or, 1);
    step();
    chk("R12", "edge3 first word", rdata, 18'h11111);
    chk("R4", "edge3 ef_or", ef_or, 0);
    step(); step();
    chk("R4", "first word held", rdata, 18'h11111);
    wr(18'h22222);
    wr(18'h33333);
    repeat (4) step();
    rd();
    chk("R4", "second word", rdata, 18'h22222);
    chk("R4", "ef_or after second", ef_or, 0);
    rd();
    chk("R4", "third word", rdata, 18'h33333);
    rd();
    chk("R4", "ef_or after last consumed", ef_or, 1);
    chk("R4", "rdata kept", rdata, 18'h33333);

    finish_run();
  end
endmodule